// File: doc/BRIEF.md
# Gated Cascaded Timer/Counter

This block is one timer/counter channel made of a high count byte and a low count byte. At run time it works either as a 13-bit counter or as a 16-bit counter. In 13-bit form, the whole high byte sits above the five least significant bits of the low byte. In 16-bit form, both bytes make one 16-bit count. No prescaler sits in front of the count: each qualified tick adds exactly one.

A tick counts only when three conditions hold together: the count-enable tick is high, the software run bit is set, and the gate condition holds. The gate condition holds when the gate bit is clear or when the external gate pin is high. When the count wraps from all ones to all zeros, the overflow flag is set. The flag stays set until an interrupt acknowledge pulse clears it, or until software writes it directly. Software can load either count byte at any time with a byte write.

Top module: `gated_timer`

## Requirements
- R1: After a synchronous reset, both count bytes and the overflow flag are 0.
- R2: In 16-bit mode (`wide_mode`=1), the count `{cnt_hi,cnt_lo}` increases by exactly one on each rising clock edge where `tick_en`=1, `run`=1 and (`gate_en`=0 or `gate_pin`=1). A carry passes from the low byte into the high byte.
- R3: When `run`=0, or when `gate_en`=1 with `gate_pin`=0, or when `tick_en`=0, both count bytes hold their value.
- R4: Clearing or setting `run` never changes the count bytes.
- R5: An increment from 0xFFFF in 16-bit mode gives 0x0000 and sets `ovf_flag` on the same edge.
- R6: In 13-bit mode (`wide_mode`=0), the count is `{cnt_hi, cnt_lo[4:0]}`. A carry out of `cnt_lo` bit 4 increments `cnt_hi`.
- R7: In 13-bit mode, counting never alters `cnt_lo[7:5]`. Overflow happens when `cnt_hi`=0xFF and `cnt_lo[4:0]`=0x1F, whatever the value of `cnt_lo[7:5]`.
- R8: A pulse on `ack` clears `ovf_flag` on the next edge.
- R9: A write (`hi_we` or `lo_we`) loads `wr_data` into the selected byte. Any write in a cycle cancels that cycle's increment, so the byte that is not written keeps its value.
- R10: If an overflow and an `ack` occur in the same cycle, `ovf_flag` ends up set.
- R11: When `flag_we`=1 and there is no overflow, `ovf_flag` takes the value of `flag_wdata`. An overflow in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable tick |
| run | input | 1 | Software run bit |
| gate_en | input | 1 | Gate bit; when set, counting also needs gate_pin high |
| gate_pin | input | 1 | External gate pin |
| wide_mode | input | 1 | 1 = 16-bit count, 0 = 13-bit count |
| ack | input | 1 | Interrupt acknowledge pulse; clears the flag |
| hi_we | input | 1 | Write strobe for the high byte |
| lo_we | input | 1 | Write strobe for the low byte |
| wr_data | input | 8 | Byte written by hi_we or lo_we |
| flag_we | input | 1 | Direct write strobe for the flag |
| flag_wdata | input | 1 | Value for a direct flag write |
| cnt_hi | output | 8 | High count byte |
| cnt_lo | output | 8 | Low count byte |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Both count bytes and the flag come straight out of registers. Any wrong internal state therefore shows up at the ports on the very edge where it arises. A broken carry chain or a wrong 13-bit boundary shows up as a wrong byte value after the increment that crosses the boundary. A wrong gating term shows up as a count that moves when it must hold, or holds when it must move, within one tick. The flag priority order is checked by driving overflow together with ack or with a flag write, and then reading the flag one cycle later.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int BYTE_W   = 8;
  localparam int NARROW_L = 5;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } gt_mode_e;
endpackage

// File: rtl/gt_qualify.sv
module gt_qualify (
  input  logic tick_en,
  input  logic run,
  input  logic gate_en,
  input  logic gate_pin,
  output logic count_en
);
  always_comb count_en = tick_en & run & (~gate_en | gate_pin);
endmodule

// File: rtl/gt_chain.sv
module gt_chain #(
  parameter int BYTE_W   = gt_pkg::BYTE_W,
  parameter int NARROW_L = gt_pkg::NARROW_L
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic              wide_mode,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              wrap
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int NARR_W = BYTE_W + NARROW_L;

  logic              any_wr;
  logic              step;
  logic [WIDE_W-1:0] next_wide;
  logic [NARR_W-1:0] next_narr;
  logic              full_wide;
  logic              full_narr;

  always_comb begin
    any_wr    = hi_we | lo_we;
    step      = count_en & ~any_wr;
    next_wide = {cnt_hi, cnt_lo} + WIDE_W'(1);
    next_narr = {cnt_hi, cnt_lo[NARROW_L-1:0]} + NARR_W'(1);
    full_wide = &{cnt_hi, cnt_lo};
    full_narr = &{cnt_hi, cnt_lo[NARROW_L-1:0]};
    wrap      = step & (wide_mode ? full_wide : full_narr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hi <= '0;
      cnt_lo <= '0;
    end else begin
      if (hi_we) cnt_hi <= wr_data;
      if (lo_we) cnt_lo <= wr_data;
      if (step) begin
        if (wide_mode == gt_pkg::MODE_WIDE) begin
          {cnt_hi, cnt_lo} <= next_wide;
        end else begin
          cnt_hi                 <= next_narr[NARR_W-1:NARROW_L];
          cnt_lo[NARROW_L-1:0]   <= next_narr[NARROW_L-1:0];
        end
      end
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !hi_we && !lo_we) |=> $stable({cnt_hi, cnt_lo}));

  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && !lo_we) |=> $stable(cnt_lo[BYTE_W-1:NARROW_L]));

  // R9
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (cnt_hi == $past(wr_data)));

  // R9
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (cnt_lo == $past(wr_data)));
endmodule

// File: rtl/gt_flag.sv
module gt_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic ack,
  input  logic flag_we,
  input  logic flag_wdata,
  output logic ovf_flag
);
  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (flag_we) ovf_flag <= flag_wdata;
    else if (ack)     ovf_flag <= 1'b0;
  end

  // R5
  wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_flag);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !wrap && !flag_we) |=> !ovf_flag);

  // R11
  flag_write_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !wrap) |=> (ovf_flag == $past(flag_wdata)));
endmodule

// File: rtl/gated_timer.sv
module gated_timer #(
  parameter int BYTE_W   = gt_pkg::BYTE_W,
  parameter int NARROW_L = gt_pkg::NARROW_L
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              run,
  input  logic              gate_en,
  input  logic              gate_pin,
  input  logic              wide_mode,
  input  logic              ack,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_we,
  input  logic              flag_wdata,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              ovf_flag
);
  logic count_en;
  logic wrap;

  gt_qualify u_qual (
    .tick_en (tick_en),
    .run     (run),
    .gate_en (gate_en),
    .gate_pin(gate_pin),
    .count_en(count_en)
  );

  gt_chain #(.BYTE_W(BYTE_W), .NARROW_L(NARROW_L)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .wide_mode(wide_mode),
    .hi_we    (hi_we),
    .lo_we    (lo_we),
    .wr_data  (wr_data),
    .cnt_hi   (cnt_hi),
    .cnt_lo   (cnt_lo),
    .wrap     (wrap)
  );

  gt_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .ack       (ack),
    .flag_we   (flag_we),
    .flag_wdata(flag_wdata),
    .ovf_flag  (ovf_flag)
  );

  // R4
  run_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($changed(run) && !$past(tick_en) && !hi_we && !lo_we && !tick_en)
      |=> $stable({cnt_hi, cnt_lo}));

  // R2
  wide_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count_en && wide_mode && !hi_we && !lo_we)
      |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 16'(1)));
endmodule

// File: tb/tb_gated_timer.sv
module tb_gated_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en, run, gate_en, gate_pin, wide_mode, ack;
  logic       hi_we, lo_we, flag_we, flag_wdata;
  logic [7:0] wr_data;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf_flag;
  int         n_run  = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  gated_timer dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run(run), .gate_en(gate_en),
    .gate_pin(gate_pin), .wide_mode(wide_mode), .ack(ack), .hi_we(hi_we),
    .lo_we(lo_we), .wr_data(wr_data), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    tick_en = 0; run = 0; gate_en = 0; gate_pin = 0; ack = 0;
    hi_we = 0; lo_we = 0; flag_we = 0; flag_wdata = 0; wr_data = 8'h00;
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    hi_we = 1; wr_data = h; cyc(1); hi_we = 0;
    lo_we = 1; wr_data = l; cyc(1); lo_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 hi", cnt_hi, 0); chk("R1 lo", cnt_lo, 0); chk("R1 flag", ovf_flag, 0);
  endtask

  task automatic t_count_wide();
    wide_mode = 1; load(8'h12, 8'hFE);
    tick_en = 1; run = 1; cyc(3); tick_en = 0; cyc(1);
    chk("R2 carry", {cnt_hi, cnt_lo}, 16'h1301);
    chk("R2 no flag", ovf_flag, 0);
  endtask

  task automatic t_gating();
    wide_mode = 1; load(8'h00, 8'h10);
    tick_en = 1; run = 1; gate_en = 1; gate_pin = 0; cyc(2);
    chk("R3 gate pin low", {cnt_hi, cnt_lo}, 16'h0010);
    gate_pin = 1; cyc(2);
    chk("R3 gate pin high", {cnt_hi, cnt_lo}, 16'h0012);
    run = 0; cyc(2);
    chk("R4 run cleared holds", {cnt_hi, cnt_lo}, 16'h0012);
    tick_en = 0; run = 1; cyc(2);
    chk("R3 no tick", {cnt_hi, cnt_lo}, 16'h0012);
    run = 0; cyc(1); run = 1; cyc(1);
    chk("R4 run toggle keeps", {cnt_hi, cnt_lo}, 16'h0012);
    gate_en = 0; gate_pin = 0; run = 0;
  endtask

  task automatic t_ovf_wide();
    wide_mode = 1; load(8'hFF, 8'hFF);
    tick_en = 1; run = 1; cyc(1); tick_en = 0; run = 0;
    chk("R5 wrap count", {cnt_hi, cnt_lo}, 0);
    chk("R5 flag set", ovf_flag, 1);
    cyc(2);
    chk("R5 flag sticky", ovf_flag, 1);
    ack = 1; cyc(1); ack = 0;
    chk("R8 ack clears", ovf_flag, 0);
  endtask

  task automatic t_narrow();
    wide_mode = 0; load(8'h00, 8'hBF);
    tick_en = 1; run = 1; cyc(1); tick_en = 0; run = 0;
    chk("R6 bit4 carry hi", cnt_hi, 8'h01);
    chk("R7 upper kept", cnt_lo, 8'hA0);
    load(8'hFF, 8'hFF);
    tick_en = 1; run = 1; cyc(1); tick_en = 0; run = 0;
    chk("R7 narrow wrap hi", cnt_hi, 0);
    chk("R7 narrow wrap lo", cnt_lo, 8'hE0);
    chk("R7 narrow flag", ovf_flag, 1);
    ack = 1; cyc(1); ack = 0;
    load(8'hFF, 8'h1E);
    tick_en = 1; run = 1; cyc(1); tick_en = 0; run = 0;
    chk("R6 narrow step", cnt_lo, 8'h1F);
    chk("R7 no early flag", ovf_flag, 0);
    wide_mode = 1;
  endtask

  task automatic t_write_prio();
    wide_mode = 1; load(8'h40, 8'h20);
    tick_en = 1; run = 1;
    lo_we = 1; wr_data = 8'h55; cyc(1); lo_we = 0;
    tick_en = 0; run = 0;
    chk("R9 lo written", cnt_lo, 8'h55);
    chk("R9 hi untouched", cnt_hi, 8'h40);
    load(8'hFF, 8'hFF);
    tick_en = 1; run = 1; hi_we = 1; wr_data = 8'hFF; cyc(1); hi_we = 0;
    tick_en = 0; run = 0;
    chk("R9 write blocks wrap", ovf_flag, 0);
  endtask

  task automatic t_ack_race();
    wide_mode = 1; load(8'hFF, 8'hFF);
    tick_en = 1; run = 1; ack = 1; cyc(1);
    tick_en = 0; run = 0; ack = 0;
    chk("R10 wrap beats ack", ovf_flag, 1);
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic t_flag_write();
    flag_we = 1; flag_wdata = 1; cyc(1); flag_we = 0;
    chk("R11 flag write 1", ovf_flag, 1);
    flag_we = 1; flag_wdata = 0; cyc(1); flag_we = 0;
    chk("R11 flag write 0", ovf_flag, 0);
    load(8'hFF, 8'hFF);
    tick_en = 1; run = 1; flag_we = 1; flag_wdata = 0; cyc(1);
    tick_en = 0; run = 0; flag_we = 0;
    chk("R11 wrap beats write", ovf_flag, 1);
  endtask

  initial begin
    idle(); wide_mode = 1; rst = 1;
    cyc(3); rst = 0; cyc(1);
    t_reset();
    t_count_wide();
    t_gating();
    t_ovf_wide();
    t_narrow();
    t_write_prio();
    t_ack_race();
    t_flag_write();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule